// File: doc/BRIEF.md
# Page Translation Cache

This block keeps a handful of recently used virtual-page-to-physical-frame translations and searches them all in parallel. A requester presents a page number together with a read/write flag. On a hit, the frame number, the read-only flag and any fault code are returned combinationally in the same cycle, with no memory traffic. On a miss, the block asks a page-table walker for the translation and waits for it. A successful answer is passed straight back to the requester and stored in the cache. A fault answer is only passed back.

Each cached entry carries its own copy of the page's written-in (dirty) flag. When a write reaches a writable page whose cached flag is clear, the block sets the flag locally and emits a one-cycle request asking the walker to set the same flag in the page table. Later writes to that page cause no further page-table traffic. A single-cycle flush pulse, used on a context change, invalidates every entry.

Top module: `page_xlat_buf`

## Requirements
- R1: A request accepted while `reqReady` is high whose page matches a valid entry gets `respValid` in that same cycle, with the stored frame and read-only flag. No walk request follows.
- R2: A request that misses raises `walkReqValid` with the same page from the next cycle. It holds both steady, with `reqReady` low, until the cycle in which `walkRespValid` is high.
- R3: A non-fault walker answer produces `respValid` in the same cycle, carrying the walker's frame and read-only flag. The translation is stored, so a later request to that page hits.
- R4: A walker answer with its fault flag set produces `respValid` with `respFault` = 1 and stores nothing, so the same page misses again.
- R5: A write that hits a writable entry whose cached written-in flag is clear pulses `dirtyUpdValid` in that cycle, with `dirtyUpdPage` equal to the page, and sets the cached flag.
- R6: A write that hits a writable entry whose cached written-in flag is already set produces no `dirtyUpdValid`.
- R7: A write to a read-only page returns `respFault` = 2, with no `dirtyUpdValid`. When the write hits, no walk is started and the entry stays usable. A fault-free response carries `respFault` = 0.
- R8: A new translation goes into the lowest-numbered invalid slot. When all 8 slots are valid, it goes into the slot named by a round-robin pointer that starts at slot 0 after reset and advances by one, wrapping, on each such replacement. A flush does not move the pointer.
- R9: `flushPulse` invalidates every entry in one cycle. A request in the same cycle is handled as a miss. A walker answer arriving in the same cycle as a flush is still returned to the requester but is not stored.
- R10: After reset, all entries are invalid, `reqReady` is high, and `respValid`, `walkReqValid` and `dirtyUpdValid` are low.
- R11: A write that misses and gets a fault-free, writable answer whose written-in flag is clear pulses `dirtyUpdValid` with the response, and stores the entry with its flag set. An answer whose written-in flag is already set causes no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushPulse | input | 1 | Invalidate all entries |
| reqValid | input | 1 | Translation request present |
| reqWrite | input | 1 | Request is a write |
| reqPage | input | 23 | Virtual page number |
| reqReady | output | 1 | Block can accept a request |
| respValid | output | 1 | Response valid |
| respFrame | output | 23 | Physical frame number |
| respReadOnly | output | 1 | Page is read-only |
| respFault | output | 2 | 0 none, 1 walker fault, 2 protection |
| walkReqValid | output | 1 | Walk request outstanding |
| walkReqPage | output | 23 | Page to walk |
| walkRespValid | input | 1 | Walker answer present |
| walkRespFault | input | 1 | Page unmapped or not resident |
| walkRespFrame | input | 23 | Frame from page table |
| walkRespReadOnly | input | 1 | Read-only flag from page table |
| walkRespWritten | input | 1 | Written-in flag from page table |
| dirtyUpdValid | output | 1 | Set written-in flag in page table |
| dirtyUpdPage | output | 23 | Page for that update |

## Verification
The assertions assume three things about the inputs. The walker answers only while a walk request is outstanding. The update request is accepted in the cycle it is issued. The requester holds a request only for the cycle in which it is accepted. The stimulus keeps to these assumptions: a single task drives each request for exactly one accepted cycle, and walker answers are produced only after the bench has observed `walkReqValid`, with a random delay of zero to two cycles. Pages are drawn from a small pool so that hits, evictions, faults and read-only pages occur often.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_WALK = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  typedef struct packed {
    logic flushAll;
    logic install;
    logic installDirty;
    logic markDirty;
  } store_cmd_t;
endpackage

// File: rtl/pxb_store.sv
module pxb_store
  import pxb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PAGE_W  = 23,
  parameter int FRAME_W = 23
) (
  input  logic               clk,
  input  logic               rstN,
  input  store_cmd_t         cmd,
  input  logic [PAGE_W-1:0]  lookupPage,
  input  logic [PAGE_W-1:0]  installPage,
  input  logic [FRAME_W-1:0] installFrame,
  input  logic               installRo,
  output logic               hit,
  output logic [FRAME_W-1:0] hitFrame,
  output logic               hitRo,
  output logic               hitDirty
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid, roBits, dirtyBits, matchVec;
  logic [PAGE_W-1:0]  pageTab  [ENTRIES];
  logic [FRAME_W-1:0] frameTab [ENTRIES];
  logic [IDX_W-1:0]   hitIdx, freeIdx, victim, rrPtr;
  logic               anyFree;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign matchVec[g] = valid[g] && (pageTab[g] == lookupPage);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (matchVec[i]) hitIdx = IDX_W'(i);
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid[i]) freeIdx = IDX_W'(i);
  end

  assign hit      = |matchVec;
  assign hitFrame = frameTab[hitIdx];
  assign hitRo    = roBits[hitIdx];
  assign hitDirty = dirtyBits[hitIdx];
  assign anyFree  = ~&valid;
  assign victim   = anyFree ? freeIdx : rrPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid     <= '0;
      dirtyBits <= '0;
      rrPtr     <= '0;
    end else begin
      if (cmd.flushAll) begin
        valid <= '0;
      end else if (cmd.install) begin
        valid[victim]     <= 1'b1;
        dirtyBits[victim] <= cmd.installDirty;
        if (!anyFree) rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
      end
      if (cmd.markDirty) dirtyBits[hitIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.install && !cmd.flushAll) begin
      pageTab[victim]  <= installPage;
      frameTab[victim] <= installFrame;
      roBits[victim]   <= installRo;
    end
  end
endmodule

// File: rtl/pxb_ctrl.sv
module pxb_ctrl
  import pxb_pkg::*;
#(
  parameter int PAGE_W  = 23,
  parameter int FRAME_W = 23
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flushPulse,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [PAGE_W-1:0]  reqPage,
  output logic               reqReady,
  output logic               respValid,
  output logic [FRAME_W-1:0] respFrame,
  output logic               respReadOnly,
  output logic [1:0]         respFault,
  output logic               walkReqValid,
  output logic [PAGE_W-1:0]  walkReqPage,
  input  logic               walkRespValid,
  input  logic               walkRespFault,
  input  logic [FRAME_W-1:0] walkRespFrame,
  input  logic               walkRespReadOnly,
  input  logic               walkRespWritten,
  output logic               dirtyUpdValid,
  output logic [PAGE_W-1:0]  dirtyUpdPage,
  output store_cmd_t         cmd,
  output logic [PAGE_W-1:0]  pendPage,
  input  logic               hit,
  input  logic [FRAME_W-1:0] hitFrame,
  input  logic               hitRo,
  input  logic               hitDirty
);
  typedef enum logic {ST_IDLE, ST_WALK} state_e;
  state_e state;
  logic   pendWrite;
  logic   lookHit;
  fault_e fault;

  assign lookHit = hit && !flushPulse;

  always_comb begin
    reqReady      = 1'b0;
    respValid     = 1'b0;
    respFrame     = '0;
    respReadOnly  = 1'b0;
    fault         = FLT_NONE;
    walkReqValid  = 1'b0;
    walkReqPage   = pendPage;
    dirtyUpdValid = 1'b0;
    dirtyUpdPage  = '0;
    cmd           = '0;
    cmd.flushAll  = flushPulse;
    if (state == ST_IDLE) begin
      reqReady = 1'b1;
      if (reqValid && lookHit) begin
        respValid    = 1'b1;
        respFrame    = hitFrame;
        respReadOnly = hitRo;
        if (reqWrite && hitRo) begin
          fault = FLT_PROT;
        end else if (reqWrite && !hitDirty) begin
          cmd.markDirty = 1'b1;
          dirtyUpdValid = 1'b1;
          dirtyUpdPage  = reqPage;
        end
      end
    end else begin
      walkReqValid = 1'b1;
      if (walkRespValid) begin
        respValid    = 1'b1;
        respFrame    = walkRespFrame;
        respReadOnly = walkRespReadOnly;
        if (walkRespFault) begin
          fault = FLT_WALK;
        end else begin
          cmd.install      = !flushPulse;
          cmd.installDirty = walkRespWritten || (pendWrite && !walkRespReadOnly);
          if (pendWrite && walkRespReadOnly) begin
            fault = FLT_PROT;
          end else if (pendWrite && !walkRespWritten) begin
            dirtyUpdValid = 1'b1;
            dirtyUpdPage  = pendPage;
          end
        end
      end
    end
  end

  assign respFault = fault;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pendPage  <= '0;
      pendWrite <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (reqValid && !lookHit) begin
        state     <= ST_WALK;
        pendPage  <= reqPage;
        pendWrite <= reqWrite;
      end
    end else if (walkRespValid) begin
      state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/page_xlat_buf.sv
module page_xlat_buf
  import pxb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PAGE_W  = 23,
  parameter int FRAME_W = 23
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flushPulse,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [PAGE_W-1:0]  reqPage,
  output logic               reqReady,
  output logic               respValid,
  output logic [FRAME_W-1:0] respFrame,
  output logic               respReadOnly,
  output logic [1:0]         respFault,
  output logic               walkReqValid,
  output logic [PAGE_W-1:0]  walkReqPage,
  input  logic               walkRespValid,
  input  logic               walkRespFault,
  input  logic [FRAME_W-1:0] walkRespFrame,
  input  logic               walkRespReadOnly,
  input  logic               walkRespWritten,
  output logic               dirtyUpdValid,
  output logic [PAGE_W-1:0]  dirtyUpdPage
);
  store_cmd_t         cmd;
  logic [PAGE_W-1:0]  pendPage;
  logic               hit, hitRo, hitDirty;
  logic [FRAME_W-1:0] hitFrame;

  pxb_ctrl #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) uCtrl (
    .clk(clk), .rstN(rstN), .flushPulse(flushPulse),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqPage(reqPage), .reqReady(reqReady),
    .respValid(respValid), .respFrame(respFrame), .respReadOnly(respReadOnly),
    .respFault(respFault), .walkReqValid(walkReqValid), .walkReqPage(walkReqPage),
    .walkRespValid(walkRespValid), .walkRespFault(walkRespFault),
    .walkRespFrame(walkRespFrame), .walkRespReadOnly(walkRespReadOnly),
    .walkRespWritten(walkRespWritten), .dirtyUpdValid(dirtyUpdValid),
    .dirtyUpdPage(dirtyUpdPage), .cmd(cmd), .pendPage(pendPage),
    .hit(hit), .hitFrame(hitFrame), .hitRo(hitRo), .hitDirty(hitDirty)
  );

  pxb_store #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) uStore (
    .clk(clk), .rstN(rstN), .cmd(cmd), .lookupPage(reqPage),
    .installPage(pendPage), .installFrame(walkRespFrame), .installRo(walkRespReadOnly),
    .hit(hit), .hitFrame(hitFrame), .hitRo(hitRo), .hitDirty(hitDirty)
  );
endmodule

// File: rtl/pxb_checks.sv
module pxb_checks #(
  parameter int PAGE_W = 23
) (
  input logic              clk,
  input logic              rstN,
  input logic              flushPulse,
  input logic              reqValid,
  input logic              reqReady,
  input logic              respValid,
  input logic [1:0]        respFault,
  input logic              walkReqValid,
  input logic [PAGE_W-1:0] walkReqPage,
  input logic              walkRespValid,
  input logic              walkRespFault,
  input logic              dirtyUpdValid
);
  // R2
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    walkReqValid && !walkRespValid |=> walkReqValid && $stable(walkReqPage));

  // R9
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse && reqValid && reqReady |=> walkReqValid);

  // R7
  prot_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respFault == 2'd2 |-> !dirtyUpdValid);

  // R5
  upd_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    dirtyUpdValid |-> respValid && respFault == 2'd0);

  // R4
  walk_fault_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respFault == 2'd1 |-> walkRespValid && walkRespFault);

  // R1
  hit_no_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && respValid |=> !walkReqValid);
endmodule

bind page_xlat_buf pxb_checks #(.PAGE_W(PAGE_W)) uChk (
  .clk(clk), .rstN(rstN), .flushPulse(flushPulse), .reqValid(reqValid),
  .reqReady(reqReady), .respValid(respValid), .respFault(respFault),
  .walkReqValid(walkReqValid), .walkReqPage(walkReqPage),
  .walkRespValid(walkRespValid), .walkRespFault(walkRespFault),
  .dirtyUpdValid(dirtyUpdValid)
);

// File: tb/page_xlat_buf_test.sv
`timescale 1ns/1ps
module page_xlat_buf_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flushPulse = 0, reqValid = 0, reqWrite = 0;
  logic [22:0] reqPage = '0;
  logic reqReady, respValid, respReadOnly, walkReqValid, dirtyUpdValid;
  logic [22:0] respFrame, walkReqPage, dirtyUpdPage;
  logic [1:0] respFault;
  logic walkRespValid = 0, walkRespFault = 0, walkRespReadOnly = 0, walkRespWritten = 0;
  logic [22:0] walkRespFrame = '0;

  int total = 0, bad = 0, cyc = 0;
  bit         mValid [8];
  logic [22:0] mPage [8], mFrame [8];
  bit         mRo [8], mDirty [8];
  int         mRr = 0;

  always #4 clk = ~clk;

  page_xlat_buf uut (
    .clk(clk), .rstN(rstN), .flushPulse(flushPulse), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqPage(reqPage), .reqReady(reqReady),
    .respValid(respValid), .respFrame(respFrame), .respReadOnly(respReadOnly),
    .respFault(respFault), .walkReqValid(walkReqValid), .walkReqPage(walkReqPage),
    .walkRespValid(walkRespValid), .walkRespFault(walkRespFault),
    .walkRespFrame(walkRespFrame), .walkRespReadOnly(walkRespReadOnly),
    .walkRespWritten(walkRespWritten), .dirtyUpdValid(dirtyUpdValid),
    .dirtyUpdPage(dirtyUpdPage)
  );

  function automatic logic [22:0] pg(int idx); return 23'h40000 + 23'(idx); endfunction
  function automatic logic [22:0] wFrame(int idx); return 23'(idx * 4951) ^ 23'h2A5A5; endfunction
  function automatic bit wRo(int idx); return (idx % 5) == 3; endfunction
  function automatic bit wDirty(int idx); return (idx % 4) == 1; endfunction
  function automatic bit wFault(int idx); return (idx % 11) == 10; endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic mClear();
    for (int i = 0; i < 8; i++) mValid[i] = 0;
  endtask

  task automatic mInstall(input int idx, input bit dirty);
    int slot = -1;
    for (int i = 7; i >= 0; i--) if (!mValid[i]) slot = i;
    if (slot < 0) begin slot = mRr; mRr = (mRr + 1) % 8; end
    mValid[slot] = 1; mPage[slot] = pg(idx); mFrame[slot] = wFrame(idx);
    mRo[slot] = wRo(idx); mDirty[slot] = dirty;
  endtask

  task automatic flushOnly();
    flushPulse = 1; @(negedge clk); flushPulse = 0; mClear();
  endtask

  task automatic access(input int idx, input bit wr, input bit fReq, input bit fResp,
                        input string tag);
    logic [22:0] p;
    int slot, waitN;
    bit prot, upd, flt, ro, pd;
    p = pg(idx);
    if (fReq) mClear();
    slot = -1;
    for (int i = 0; i < 8; i++) if (mValid[i] && mPage[i] == p) slot = i;
    reqValid = 1; reqWrite = wr; reqPage = p; flushPulse = fReq;
    #1;
    chk(tag, "respValid", int'(respValid), int'(slot >= 0));
    if (slot >= 0) begin
      prot = wr && mRo[slot];
      upd  = wr && !mRo[slot] && !mDirty[slot];
      chk(tag, "respFrame", int'(respFrame), int'(mFrame[slot]));
      chk(tag, "respReadOnly", int'(respReadOnly), int'(mRo[slot]));
      chk(prot ? "R7" : tag, "respFault", int'(respFault), prot ? 2 : 0);
      chk(upd ? "R5" : (wr ? "R6" : tag), "dirtyUpdValid", int'(dirtyUpdValid), int'(upd));
      if (upd) chk("R5", "dirtyUpdPage", int'(dirtyUpdPage), int'(p));
      if (upd) mDirty[slot] = 1;
      @(negedge clk); reqValid = 0; flushPulse = 0; #1;
      chk("R1", "walkReqValid after hit", int'(walkReqValid), 0);
      @(negedge clk);
    end else begin
      @(negedge clk); reqValid = 0; flushPulse = 0; #1;
      chk(fReq ? "R9" : "R2", "walkReqValid", int'(walkReqValid), 1);
      chk("R2", "walkReqPage", int'(walkReqPage), int'(p));
      chk("R2", "reqReady", int'(reqReady), 0);
      waitN = $urandom % 3;
      repeat (waitN) begin
        @(negedge clk); #1;
        chk("R2", "walkReqValid held", int'(walkReqValid), 1);
      end
      flt = wFault(idx); ro = wRo(idx); pd = wDirty(idx);
      walkRespValid = 1; walkRespFault = flt; walkRespFrame = wFrame(idx);
      walkRespReadOnly = ro; walkRespWritten = pd; flushPulse = fResp;
      #1;
      prot = !flt && wr && ro;
      upd  = !flt && wr && !ro && !pd;
      chk(flt ? "R4" : "R3", "respValid on walk", int'(respValid), 1);
      chk(flt ? "R4" : (prot ? "R7" : "R3"), "respFault", int'(respFault),
          flt ? 1 : (prot ? 2 : 0));
      if (!flt) chk("R3", "respFrame", int'(respFrame), int'(wFrame(idx)));
      chk(upd ? "R11" : tag, "dirtyUpdValid on walk", int'(dirtyUpdValid), int'(upd));
      if (upd) chk("R11", "dirtyUpdPage", int'(dirtyUpdPage), int'(p));
      @(negedge clk);
      walkRespValid = 0; flushPulse = 0;
      if (fResp) mClear();
      else if (!flt) mInstall(idx, pd || (wr && !ro));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R2 watchdog expired: actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    mClear();
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("R10", "reqReady", int'(reqReady), 1);
    chk("R10", "respValid", int'(respValid), 0);
    chk("R10", "walkReqValid", int'(walkReqValid), 0);
    chk("R10", "dirtyUpdValid", int'(dirtyUpdValid), 0);
    @(negedge clk);
    access(5, 0, 0, 0, "R10");

    // R8: fill, then round-robin replacement from slot 0
    flushOnly();
    for (int i = 0; i < 8; i++) access(i, 0, 0, 0, "R8");
    for (int i = 0; i < 8; i++) access(i, 0, 0, 0, "R3");
    access(12, 0, 0, 0, "R8");
    access(0, 0, 0, 0, "R8");
    access(2, 0, 0, 0, "R8");
    access(1, 0, 0, 0, "R8");

    // R5 / R6 / R7 / R11
    flushOnly();
    access(0, 0, 0, 0, "R3");
    access(0, 1, 0, 0, "R5");
    access(0, 1, 0, 0, "R6");
    access(3, 0, 0, 0, "R7");
    access(3, 1, 0, 0, "R7");
    access(3, 0, 0, 0, "R7");
    access(4, 1, 0, 0, "R11");
    access(4, 1, 0, 0, "R6");
    access(1, 1, 0, 0, "R11");
    access(8, 1, 0, 0, "R7");

    // R4: faults never stored
    access(10, 0, 0, 0, "R4");
    access(10, 1, 0, 0, "R4");

    // R9: flush with request, flush with walker answer
    access(0, 0, 0, 0, "R9");
    access(0, 0, 1, 0, "R9");
    access(2, 0, 0, 1, "R9");
    access(2, 0, 0, 0, "R9");

    for (int n = 0; n < 600; n++) begin
      int idx = $urandom % 24;
      bit wr  = ($urandom % 10) < 4;
      if (($urandom % 40) == 0) flushOnly();
      access(idx, wr, ($urandom % 50) == 0, ($urandom % 60) == 0, "R3");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule